// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is a watchdog that escalates through four stages. A divider turns the input clock into timer ticks. Each stage counts ticks up to its own limit. When the limit is reached, the block carries out the action chosen for that stage and moves on to the next stage. The possible actions are nothing, an interrupt, a processor reset pulse, or a whole-system reset pulse. Each reset pulse has a width chosen by a 3-bit code. Software keeps the watchdog quiet by writing the kick register before the escalation goes too far.

The block has a flat register port: one write strobe, an address, write data, and read data that follows the address combinationally. A 32-bit key register guards the configuration. The control word, the divider, the stage limits and the kick register accept writes only while the key register holds the unlock value. A boot-arm bit keeps the watchdog running even when the main enable bit is clear. The interrupt comes out in three forms: a sticky raw status, a level output and a one-cycle pulse output. The level and pulse outputs each have their own enable and share one master interrupt enable.

Top module: `escalating_wdt`

## Requirements
- R1: After reset all outputs are low, the key register, control word, stage limits and master interrupt enable read 0, and the divider reads 1.
- R2: Register map (4-bit address): 0 control, 1 divider, 2..5 limits of stages 0..3, 6 kick, 7 key, 8 raw status (read only), 9 status clear, 10 master interrupt enable. Writes to addresses 0, 1, 2..5 and 6 are ignored unless the key register holds 0x50D83AA1. Addresses 7, 9 and 10 are always writable. Writing 0 to the key register locks the block again.
- R3: While the watchdog runs, one tick occurs every P clock cycles, where P is the 16-bit divider value. A divider value of 0 behaves as 1. A new divider value applies from the current count onward.
- R4: Control word layout: bit0 enable, bit1 boot-arm, bit2 level-output enable, bit3 pulse-output enable, bits [5:4],[7:6],[9:8],[11:10] actions of stages 0..3, bits [14:12] processor pulse code, bits [17:15] system pulse code. Action codes: 0 none, 1 interrupt, 2 processor reset, 3 system reset. A stage with limit T (T = 0 treated as 1) acts on the tick that brings its tick count to T or beyond. It then moves to the next stage with the count at 0.
- R5: A stage whose action is none performs nothing, and the tick that reaches it passes straight on to the next stage.
- R6: Once stage 3 has been passed, the watchdog stays in stage 3 and takes no further action until it is kicked or stopped.
- R7: A kick clears the tick count, the divider phase and the stage, and escalation starts again from stage 0.
- R8: The watchdog runs whenever the enable bit or the boot-arm bit is set. While it is stopped, its count, phase and stage are held at 0.
- R9: An interrupt action sets the raw status. Writing 1 to bit 0 of the status-clear register clears it, and a set in the same cycle wins. The level output equals raw status AND level-output enable AND master enable.
- R10: The pulse output is high for the one cycle after an interrupt action, gated by the pulse-output enable and the master enable.
- R11: A processor- or system-reset action drives its reset output high for ceil(W / clock period) cycles, at least 1, starting the next cycle. Codes 0..7 give W = 100, 200, 300, 400, 500, 800, 1600, 3200 ns. A new action during a pulse restarts the full width.
- R12: Control, divider, limits, key and master enable read back what was accepted. The kick and status-clear registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_level_o | output | 1 | Gated level interrupt |
| irq_pulse_o | output | 1 | Gated one-cycle interrupt pulse |
| irq_raw_o | output | 1 | Raw sticky interrupt status |
| cpu_reset_o | output | 1 | Processor reset pulse |
| sys_reset_o | output | 1 | System reset pulse |

## Verification
Two situations are hard to reach from the ports. The first is the terminal hold in stage 3. The second is a kick arriving while the block is locked, because a locked kick leaves no trace unless the escalation could otherwise have restarted. The stimulus therefore lets a full four-stage run finish, clears the status, relocks the block and kicks it. It then watches for long enough that a restart would have raised the interrupt again. A second run uses zero limits and a divider of 0, so every tick changes stage. This brings about back-to-back reset actions that restart a pulse, plus an immediate skip over a stage with no action.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_STAGES = 4;
  localparam int CTRL_W     = 18;
  localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;

  localparam int A_CTRL   = 0;
  localparam int A_DIV    = 1;
  localparam int A_LIMIT0 = 2;
  localparam int A_KICK   = 6;
  localparam int A_KEY    = 7;
  localparam int A_STAT   = 8;
  localparam int A_CLR    = 9;
  localparam int A_IEN    = 10;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_IRQ      = 2'd1,
    ACT_CORE_RST = 2'd2,
    ACT_CHIP_RST = 2'd3
  } wdt_act_e;

  function automatic int unsigned pulse_cycles(input logic [2:0] code,
                                               input int unsigned clk_ns);
    int unsigned ns;
    int unsigned c;
    case (code)
      3'd0: ns = 100;
      3'd1: ns = 200;
      3'd2: ns = 300;
      3'd3: ns = 400;
      3'd4: ns = 500;
      3'd5: ns = 800;
      3'd6: ns = 1600;
      default: ns = 3200;
    endcase
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int AW = 4,
  parameter int NS = NUM_STAGES,
  parameter int TW = 32,
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic                   set_irq,
  output logic [CTRL_W-1:0]      ctrl,
  output logic [DW-1:0]          div,
  output logic [NS-1:0][TW-1:0]  limits,
  output logic                   kick,
  output logic                   irq_raw,
  output logic                   irq_en
);
  logic [31:0]           key_q, key_d;
  logic [CTRL_W-1:0]     ctrl_q, ctrl_d;
  logic [DW-1:0]         div_q, div_d;
  logic [NS-1:0][TW-1:0] lim_q, lim_d;
  logic                  ien_q, ien_d;
  logic                  raw_q, raw_d;
  logic                  unlocked;
  logic                  upd_en;

  assign unlocked = (key_q == UNLOCK_KEY);
  assign upd_en   = we | set_irq;

  always_comb begin
    key_d  = key_q;
    ctrl_d = ctrl_q;
    div_d  = div_q;
    lim_d  = lim_q;
    ien_d  = ien_q;
    raw_d  = raw_q;
    kick   = 1'b0;
    if (we) begin
      if (addr == AW'(A_KEY)) key_d = wdata;
      if (addr == AW'(A_IEN)) ien_d = wdata[0];
      if (addr == AW'(A_CLR) && wdata[0]) raw_d = 1'b0;
      if (unlocked) begin
        if (addr == AW'(A_CTRL)) ctrl_d = wdata[CTRL_W-1:0];
        if (addr == AW'(A_DIV))  div_d  = wdata[DW-1:0];
        if (addr == AW'(A_KICK)) kick   = 1'b1;
        for (int s = 0; s < NS; s++) begin
          if (addr == AW'(A_LIMIT0 + s)) lim_d[s] = wdata[TW-1:0];
        end
      end
    end
    if (set_irq) raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      ctrl_q <= '0;
      div_q  <= DW'(1);
      lim_q  <= '0;
      ien_q  <= 1'b0;
      raw_q  <= 1'b0;
    end else if (upd_en) begin
      key_q  <= key_d;
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      lim_q  <= lim_d;
      ien_q  <= ien_d;
      raw_q  <= raw_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL)) rdata = 32'(ctrl_q);
    if (addr == AW'(A_DIV))  rdata = 32'(div_q);
    if (addr == AW'(A_KEY))  rdata = key_q;
    if (addr == AW'(A_STAT)) rdata = {31'b0, raw_q};
    if (addr == AW'(A_IEN))  rdata = {31'b0, ien_q};
    for (int s = 0; s < NS; s++) begin
      if (addr == AW'(A_LIMIT0 + s)) rdata = 32'(lim_q[s]);
    end
  end

  assign ctrl    = ctrl_q;
  assign div     = div_q;
  assign limits  = lim_q;
  assign irq_raw = raw_q;
  assign irq_en  = ien_q;

  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && we && addr == AW'(A_CTRL)) |=> $stable(ctrl_q));

  assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq |=> raw_q);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(A_CLR) && wdata[0] && !set_irq) |=> !raw_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          kick,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] last;
  logic          cnt_en;

  always_comb begin
    last   = (div == '0) ? '0 : div - DW'(1);
    tick   = run && (cnt_q >= last);
    cnt_en = run || (cnt_q != '0);
    if (!run || kick || tick) cnt_d = '0;
    else                      cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick && tick) |=> (cnt_q == '0));

  assert_phase_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick && !tick) |=> (cnt_q == $past(cnt_q) + DW'(1)));
endmodule

// File: rtl/wdt_sequencer.sv
module wdt_sequencer
  import wdt_pkg::*;
#(
  parameter int NS = NUM_STAGES,
  parameter int TW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  kick,
  input  logic                  tick,
  input  logic [NS-1:0][1:0]    acts,
  input  logic [NS-1:0][TW-1:0] limits,
  output logic                  fire,
  output logic [1:0]            fire_act
);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  logic [SW-1:0] stage_q, stage_d;
  logic [TW-1:0] count_q, count_d;
  logic          done_q, done_d;
  logic [1:0]    cur_act;
  logic [TW-1:0] cur_lim;
  logic          reach, step, advance, seq_en;

  always_comb begin
    cur_act  = acts[stage_q];
    cur_lim  = limits[stage_q];
    reach    = ({1'b0, count_q} + (TW+1)'(1)) >= {1'b0, cur_lim};
    step     = run && !kick && tick && !done_q;
    advance  = step && ((cur_act == ACT_NONE) || reach);
    fire     = advance && (cur_act != ACT_NONE);
    fire_act = cur_act;
    seq_en   = !run || kick || step;

    stage_d = stage_q;
    count_d = count_q;
    done_d  = done_q;
    if (!run || kick) begin
      stage_d = '0;
      count_d = '0;
      done_d  = 1'b0;
    end else if (advance) begin
      count_d = '0;
      if (stage_q == SW'(NS-1)) done_d = 1'b1;
      else                      stage_d = stage_q + SW'(1);
    end else if (step) begin
      count_d = count_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (seq_en) begin
      stage_q <= stage_d;
      count_q <= count_d;
      done_q  <= done_d;
    end
  end

  assert_terminal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run && !kick) |=> (done_q && stage_q == SW'(NS-1) && $stable(count_q)));

  assert_kick_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (stage_q == '0 && count_q == '0 && !done_q));

  assert_fire_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (tick && run));

  assert_stopped_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (stage_q == '0 && count_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int PW     = 8,
  parameter int CLK_NS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] code,
  output logic       active
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = PW'(pulse_cycles(code, CLK_NS));
    else      cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  assert_pulse_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active);

  assert_pulse_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !active) |=> !active);
endmodule

// File: rtl/escalating_wdt.sv
module escalating_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_NS = 20,
  parameter int DW     = 16,
  parameter int TW     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_level_o,
  output logic        irq_pulse_o,
  output logic        irq_raw_o,
  output logic        cpu_reset_o,
  output logic        sys_reset_o
);
  localparam int NS = NUM_STAGES;
  localparam int PW = $clog2(3200 / CLK_NS + 2);

  logic [CTRL_W-1:0]     ctrl;
  logic [DW-1:0]         div;
  logic [NS-1:0][TW-1:0] limits;
  logic [NS-1:0][1:0]    acts;
  logic                  kick, irq_raw, irq_en, run, tick;
  logic                  fire, set_irq;
  logic [1:0]            fire_act;
  logic                  edge_q, edge_d;
  logic [1:0]            rst_vec;

  wdt_regfile #(.AW(4), .NS(NS), .TW(TW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .set_irq(set_irq), .ctrl(ctrl), .div(div),
    .limits(limits), .kick(kick), .irq_raw(irq_raw), .irq_en(irq_en)
  );

  assign run = ctrl[0] | ctrl[1];

  for (genvar s = 0; s < NS; s++) begin : g_act
    assign acts[s] = ctrl[4 + 2*s +: 2];
  end

  wdt_prescaler #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .kick(kick), .div(div), .tick(tick)
  );

  wdt_sequencer #(.NS(NS), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .kick(kick), .tick(tick),
    .acts(acts), .limits(limits), .fire(fire), .fire_act(fire_act)
  );

  assign set_irq = fire && (fire_act == ACT_IRQ);

  for (genvar g = 0; g < 2; g++) begin : g_rst
    logic       load;
    logic [2:0] code;
    assign load = fire && (fire_act == ((g == 0) ? ACT_CORE_RST : ACT_CHIP_RST));
    assign code = (g == 0) ? ctrl[14:12] : ctrl[17:15];
    wdt_pulse #(.PW(PW), .CLK_NS(CLK_NS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .load(load), .code(code), .active(rst_vec[g])
    );
  end

  always_comb edge_d = set_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= edge_d;
  end

  assign irq_raw_o   = irq_raw;
  assign irq_level_o = irq_raw & ctrl[2] & irq_en;
  assign irq_pulse_o = edge_q & ctrl[3] & irq_en;
  assign cpu_reset_o = rst_vec[0];
  assign sys_reset_o = rst_vec[1];

  assert_pulse_follows_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> $past(set_irq));
endmodule

// File: tb/sim_escalating_wdt.sv
module sim_escalating_wdt;
  localparam logic [31:0] KEYV = 32'h50D8_3AA1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_level, irq_pulse, irq_raw, cpu_rst, sys_rst;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    ended = 0;
  string phase = "R1";

  escalating_wdt u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_level_o(irq_level), .irq_pulse_o(irq_pulse),
    .irq_raw_o(irq_raw), .cpu_reset_o(cpu_rst), .sys_reset_o(sys_rst)
  );

  always #10 clk = ~clk;

  // reference model state
  logic [31:0] m_key, m_ctrl, m_div, m_ien, m_raw, m_edge;
  logic [31:0] m_lim [4];
  longint      m_cnt;
  int          m_pcnt, m_stage, m_cpu, m_sys;
  bit          m_done;
  // scratch
  bit     s_run, s_unl, s_kick, s_tick, s_fire;
  int     s_act, s_pe, n_pcnt, n_stage, n_cpu, n_sys;
  longint n_cnt;
  bit     n_done;

  function automatic int width_cycles(input int code);
    int ns;
    int c;
    case (code)
      0: ns = 100; 1: ns = 200; 2: ns = 300; 3: ns = 400;
      4: ns = 500; 5: ns = 800; 6: ns = 1600; default: ns = 3200;
    endcase
    c = (ns + 19) / 20;
    return (c < 1) ? 1 : c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_ctrl = 0; m_div = 1; m_ien = 0; m_raw = 0; m_edge = 0;
      for (int s = 0; s < 4; s++) m_lim[s] = 0;
      m_cnt = 0; m_pcnt = 0; m_stage = 0; m_cpu = 0; m_sys = 0; m_done = 0;
    end else begin
      s_run  = m_ctrl[0] | m_ctrl[1];
      s_unl  = (m_key == KEYV);
      s_kick = we && addr == 4'd6 && s_unl;
      s_pe   = (m_div == 0) ? 1 : int'(m_div);
      s_tick = s_run && (m_pcnt >= s_pe - 1);
      s_act  = int'(m_ctrl[4 + 2*m_stage +: 2]);
      s_fire = 0;
      n_pcnt = (!s_run || s_kick || s_tick) ? 0 : m_pcnt + 1;
      n_stage = m_stage; n_cnt = m_cnt; n_done = m_done;
      if (!s_run || s_kick) begin
        n_stage = 0; n_cnt = 0; n_done = 0;
      end else if (s_tick && !m_done) begin
        if (s_act == 0 || m_cnt + 1 >= longint'(m_lim[m_stage])) begin
          s_fire = (s_act != 0);
          n_cnt = 0;
          if (m_stage == 3) n_done = 1; else n_stage = m_stage + 1;
        end else n_cnt = m_cnt + 1;
      end
      n_cpu = (s_fire && s_act == 2) ? width_cycles(int'(m_ctrl[14:12])) : (m_cpu > 0 ? m_cpu - 1 : 0);
      n_sys = (s_fire && s_act == 3) ? width_cycles(int'(m_ctrl[17:15])) : (m_sys > 0 ? m_sys - 1 : 0);
      m_edge = {31'b0, s_fire && s_act == 1};
      if (s_fire && s_act == 1) m_raw = 1;
      else if (we && addr == 4'd9 && wdata[0]) m_raw = 0;
      if (we) begin
        if (addr == 4'd7) m_key = wdata;
        if (addr == 4'd10) m_ien = {31'b0, wdata[0]};
        if (s_unl) begin
          if (addr == 4'd0) m_ctrl = wdata & 32'h0003_FFFF;
          if (addr == 4'd1) m_div = {16'b0, wdata[15:0]};
          if (addr >= 4'd2 && addr <= 4'd5) m_lim[addr - 4'd2] = wdata;
        end
      end
      m_pcnt = n_pcnt; m_stage = n_stage; m_cnt = n_cnt; m_done = n_done;
      m_cpu = n_cpu; m_sys = n_sys;
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_div;
      4'd2, 4'd3, 4'd4, 4'd5: return m_lim[a - 4'd2];
      4'd7: return m_key;
      4'd8: return m_raw;
      4'd10: return m_ien;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp({31'b0, irq_raw},   m_raw, "irq_raw (R9)");
    cmp({31'b0, irq_level}, {31'b0, m_raw[0] & m_ctrl[2] & m_ien[0]}, "irq_level (R9)");
    cmp({31'b0, irq_pulse}, {31'b0, m_edge[0] & m_ctrl[3] & m_ien[0]}, "irq_pulse (R10)");
    cmp({31'b0, cpu_rst},   {31'b0, m_cpu != 0}, "cpu_reset (R11)");
    cmp({31'b0, sys_rst},   {31'b0, m_sys != 0}, "sys_reset (R11)");
    cmp(rdata, model_rd(addr), "reg_rdata (R12)");
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = 4'(a); wdata = d;
    @(posedge clk); #2;
    we = 1'b0; addr = 4'd8;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string what);
    @(posedge clk); #2;
    addr = 4'(a);
    #5;
    cmp(rdata, exp, what);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      summary();
    end
  end

  initial begin
    phase = "R1";
    idle(4); #2 rst_n = 1'b1;
    idle(2);
    #3;
    cmp({27'b0, irq_raw, irq_level, irq_pulse, cpu_rst, sys_rst}, 32'd0, "R1 outputs after reset");
    rd_check(1, 32'd1, "R1 divider reset value");
    rd_check(7, 32'd0, "R1 key reset value");

    phase = "R2";
    wr(0, 32'h1);
    rd_check(0, 32'd0, "R2 control write ignored while locked");
    wr(7, KEYV);
    rd_check(7, KEYV, "R2 key readback");
    wr(7, 32'd0);
    wr(1, 32'd5);
    rd_check(1, 32'd1, "R2 divider write ignored after relock");

    phase = "R12";
    wr(7, KEYV);
    wr(1, 32'd3);
    wr(2, 32'd2); wr(3, 32'd1); wr(4, 32'd5); wr(5, 32'd2);
    wr(10, 32'd1);
    rd_check(4, 32'd5, "R12 stage 2 limit readback");
    rd_check(1, 32'd3, "R12 divider readback");
    rd_check(6, 32'd0, "R12 kick reads zero");

    phase = "R3";
    wr(0, 32'h0001_1C9D);
    idle(8);
    phase = "R4"; idle(12);
    phase = "R5"; idle(15);
    phase = "R6"; idle(50);

    phase = "R9";
    wr(9, 32'd1);
    idle(2); #3;
    cmp({31'b0, irq_raw}, 32'd0, "R9 status cleared");

    phase = "R7";
    wr(6, 32'd0); idle(7);
    wr(6, 32'd0); idle(45);

    phase = "R2";
    wr(9, 32'd1);
    wr(7, 32'd0);
    wr(6, 32'd0);
    idle(30); #3;
    cmp({31'b0, irq_raw}, 32'd0, "R2 kick ignored while locked");

    phase = "R8";
    wr(7, KEYV);
    wr(0, 32'h0001_1C9C);
    idle(5);
    wr(0, 32'h0001_1C9E);
    idle(40); #3;
    cmp({31'b0, irq_raw}, 32'd1, "R8 boot-arm runs with enable clear");
    wr(0, 32'h0001_1C9C);
    wr(9, 32'd1);
    idle(20);

    phase = "R11";
    wr(1, 32'd0);
    wr(2, 32'd0); wr(3, 32'd0); wr(4, 32'd0); wr(5, 32'd0);
    wr(0, 32'h0000_77A1);
    idle(200);
    wr(0, 32'h0);
    wr(0, 32'h0001_0321);
    idle(30);

    phase = "R10";
    wr(0, 32'h0);
    wr(1, 32'd2); wr(2, 32'd1);
    wr(0, 32'h0000_0019);
    idle(10);
    wr(10, 32'd0);
    wr(6, 32'd0);
    idle(10);
    wr(10, 32'd1);
    wr(0, 32'h0000_0015);
    wr(6, 32'd0);
    idle(10);

    phase = "R3";
    wr(0, 32'h0);
    wr(1, 32'd4); wr(2, 32'd3);
    wr(0, 32'h0000_001D);
    idle(6);
    wr(1, 32'd2);
    idle(30);

    ended = 1;
    idle(2);
    summary();
  end
endmodule